// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two 64-bit IEEE-754 double-precision operands. It reports the relation between them as a one-hot, four-bit condition code, together with two exception flags. The relation follows the IEEE special-case rules, not a raw magnitude compare:

- Not-a-number operands give an unordered result.
- Zeros compare equal whatever their sign.
- Signs settle the result before any magnitude is looked at.
- Infinities rank above every finite value.

One control input chooses between two variants of the compare. The *quiet* variant reports invalid only for signalling NaNs. The *signalling* (ordered) variant also flags every NaN operand as an invalid compare.

Operands enter on a valid-only stream. `start_i` acts as the input valid, and the block is always ready, so it accepts a compare on every cycle, back to back, with no back-pressure. The result leaves on a valid-only stream as well. `done_o` pulses for one cycle exactly one cycle after each accepted `start_i`. The downstream logic must take the result in that cycle, because the block cannot be stalled. The condition code and the flags are registered and keep their values until the next compare replaces them. The flags are never accumulated across compares.

Top module: `fpcmp_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all outputs (`done_o`, `cc_o`, `snan_o`, `invalid_o`) become 0.
- R2: Every cycle with `start_i` high is accepted. `done_o` is high in the cycle after such a cycle and low after every cycle with `start_i` low, so back-to-back starts give back-to-back results.
- R3: `cc_o` bit 3 means less (A<B), bit 2 greater, bit 1 equal and bit 0 unordered. After every compare exactly one of these bits is set.
- R4: A NaN is an operand whose exponent field (bits 62:52) is all ones and whose fraction (bits 51:0) is nonzero. If either operand is a NaN, `cc_o` is 4'b0001.
- R5: A signalling NaN is a NaN with fraction bit 51 equal to 0. If either operand is one, `snan_o` is 1 in both variants; otherwise it is 0.
- R6: With `ordered_i`=1, any NaN operand, quiet or signalling, sets `invalid_o`. With `ordered_i`=0, `invalid_o` is always 0.
- R7: +0 and -0 compare equal in every sign combination.
- R8: When the signs (bit 63) differ and the operands are not both zero, the negative operand is the lesser. This includes -0 against a positive nonzero value.
- R9: With equal signs, magnitudes rank infinity above finite above zero. The outcome is reversed when both operands are negative.
- R10: Two infinities of the same sign compare equal.
- R11: Two finite nonzero operands of the same sign, subnormals included, are ordered by numeric value, and equal values give equal.
- R12: Outside a `done_o` cycle the condition code and both flags keep their last values. Each compare replaces the flags rather than adding to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Input valid; the operands are taken in this cycle |
| ordered_i | input | 1 | 1 = signalling (ordered) compare, 0 = quiet compare |
| op_a_i | input | 64 | Operand A, IEEE-754 double |
| op_b_i | input | 64 | Operand B, IEEE-754 double |
| done_o | output | 1 | Result valid, one cycle after start |
| cc_o | output | 4 | Condition code {less, greater, equal, unordered} |
| snan_o | output | 1 | A signalling NaN was seen in the last compare |
| invalid_o | output | 1 | Ordered compare met a NaN operand |

## Verification
The hardest cases to reach are the ones where the sign, the class ranking and the magnitude decision all compete:

- -0 against a tiny negative subnormal.
- Two negative values whose bit patterns differ only in a low fraction chunk.
- A signalling NaN paired with a quiet NaN in the quiet variant.

Uniformly random 64-bit patterns almost never produce these, so the stimulus draws each operand from a weighted set: signed zeros, infinities, both NaN kinds, subnormals, normals, and copies of the other operand with one low bit flipped. Directed pairs then pin each boundary. Back-to-back starts with alternating variants check that the flags are replaced on every compare and never accumulated.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam int FP_EXP_W  = 11;
  localparam int FP_FRAC_W = 52;

  // Operand class, ordered by magnitude rank for non-NaN values
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_FIN  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } opclass_e;

  // Condition code, bit 3 down to bit 0
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic un;
  } cc_t;

  localparam cc_t CC_NONE = '{lt: 1'b0, gt: 1'b0, eq: 1'b0, un: 1'b0};

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W,
  localparam int OP_W  = 1 + EXP_W + FRAC_W,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic [OP_W-1:0]  op_i,
  output logic             sign_o,
  output opclass_e         cls_o,
  output logic             snan_o,
  output logic [MAG_W-1:0] mag_o
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              exp_min;
  logic              frac_zero;

  assign sign_o    = op_i[OP_W-1];
  assign exp_f     = op_i[MAG_W-1:FRAC_W];
  assign frac_f    = op_i[FRAC_W-1:0];
  assign mag_o     = op_i[MAG_W-1:0];
  assign exp_max   = &exp_f;
  assign exp_min   = ~|exp_f;
  assign frac_zero = ~|frac_f;

  always_comb begin
    if (exp_max && !frac_zero)      cls_o = CLS_NAN;
    else if (exp_max)               cls_o = CLS_INF;
    else if (exp_min && frac_zero)  cls_o = CLS_ZERO;
    else                            cls_o = CLS_FIN;
  end

  // quiet bit is the top fraction bit; clear means signalling
  assign snan_o = exp_max && !frac_zero && !frac_f[FRAC_W-1];

endmodule

// File: rtl/fpcmp_magcmp.sv
module fpcmp_magcmp #(
  parameter int MAG_W   = 63,
  parameter int CHUNK_W = 9,
  localparam int N_CHUNK = (MAG_W + CHUNK_W - 1) / CHUNK_W,
  localparam int PAD_W   = N_CHUNK * CHUNK_W
) (
  input  logic [MAG_W-1:0] a_i,
  input  logic [MAG_W-1:0] b_i,
  output logic             lt_o,
  output logic             eq_o
);

  logic [PAD_W-1:0]   a_pad;
  logic [PAD_W-1:0]   b_pad;
  logic [N_CHUNK-1:0] chunk_lt;
  logic [N_CHUNK-1:0] chunk_eq;

  generate
    if (PAD_W > MAG_W) begin : g_pad
      assign a_pad = {{(PAD_W-MAG_W){1'b0}}, a_i};
      assign b_pad = {{(PAD_W-MAG_W){1'b0}}, b_i};
    end else begin : g_nopad
      assign a_pad = a_i;
      assign b_pad = b_i;
    end
  endgenerate

  // independent narrow comparators, one per chunk
  generate
    for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
      logic [CHUNK_W-1:0] a_c;
      logic [CHUNK_W-1:0] b_c;
      assign a_c         = a_pad[c*CHUNK_W +: CHUNK_W];
      assign b_c         = b_pad[c*CHUNK_W +: CHUNK_W];
      assign chunk_lt[c] = a_c < b_c;
      assign chunk_eq[c] = a_c == b_c;
    end
  endgenerate

  // the most significant unequal chunk decides
  always_comb begin
    logic decided;
    lt_o    = 1'b0;
    decided = 1'b0;
    for (int c = N_CHUNK - 1; c >= 0; c--) begin
      if (!decided && !chunk_eq[c]) begin
        lt_o    = chunk_lt[c];
        decided = 1'b1;
      end
    end
  end

  assign eq_o = &chunk_eq;

endmodule

// File: rtl/fpcmp_decide.sv
module fpcmp_decide
  import fpcmp_pkg::*;
(
  input  logic     ordered_i,
  input  logic     sign_a_i,
  input  opclass_e cls_a_i,
  input  logic     snan_a_i,
  input  logic     sign_b_i,
  input  opclass_e cls_b_i,
  input  logic     snan_b_i,
  input  logic     mag_lt_i,
  input  logic     mag_eq_i,
  output cc_t      cc_o,
  output logic     snan_o,
  output logic     invalid_o
);

  logic any_nan;
  logic both_zero;
  logic abs_lt;
  logic abs_gt;
  logic abs_eq;

  assign any_nan   = (cls_a_i == CLS_NAN) || (cls_b_i == CLS_NAN);
  assign both_zero = (cls_a_i == CLS_ZERO) && (cls_b_i == CLS_ZERO);

  // magnitude relation: class rank first, then bit magnitude
  always_comb begin
    abs_lt = 1'b0;
    abs_gt = 1'b0;
    abs_eq = 1'b0;
    if (cls_a_i != cls_b_i) begin
      abs_lt = cls_a_i < cls_b_i;
      abs_gt = !abs_lt;
    end else if (cls_a_i == CLS_FIN) begin
      abs_eq = mag_eq_i;
      abs_lt = mag_lt_i;
      abs_gt = !mag_lt_i && !mag_eq_i;
    end else begin
      abs_eq = 1'b1;
    end
  end

  always_comb begin
    cc_o = CC_NONE;
    if (any_nan) begin
      cc_o.un = 1'b1;
    end else if (both_zero) begin
      cc_o.eq = 1'b1;
    end else if (sign_a_i != sign_b_i) begin
      cc_o.lt = sign_a_i;
      cc_o.gt = !sign_a_i;
    end else begin
      cc_o.eq = abs_eq;
      cc_o.lt = sign_a_i ? abs_gt : abs_lt;
      cc_o.gt = sign_a_i ? abs_lt : abs_gt;
    end
  end

  assign snan_o    = snan_a_i || snan_b_i;
  assign invalid_o = ordered_i && any_nan;

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W   = FP_EXP_W,
  parameter int FRAC_W  = FP_FRAC_W,
  parameter int CHUNK_W = 9,
  localparam int OP_W   = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = EXP_W + FRAC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            ordered_i,
  input  logic [OP_W-1:0] op_a_i,
  input  logic [OP_W-1:0] op_b_i,
  output logic            done_o,
  output logic [3:0]      cc_o,
  output logic            snan_o,
  output logic            invalid_o
);

  logic             sign_a, sign_b;
  opclass_e         cls_a, cls_b;
  logic             snan_a, snan_b;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic             mag_lt, mag_eq;
  cc_t              cc_next;
  logic             snan_next, inv_next;

  cc_t  cc_q;
  logic done_q, snan_q, inv_q;

  fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .op_i(op_a_i), .sign_o(sign_a), .cls_o(cls_a), .snan_o(snan_a), .mag_o(mag_a)
  );

  fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .op_i(op_b_i), .sign_o(sign_b), .cls_o(cls_b), .snan_o(snan_b), .mag_o(mag_b)
  );

  fpcmp_magcmp #(.MAG_W(MAG_W), .CHUNK_W(CHUNK_W)) u_mag (
    .a_i(mag_a), .b_i(mag_b), .lt_o(mag_lt), .eq_o(mag_eq)
  );

  fpcmp_decide u_dec (
    .ordered_i (ordered_i),
    .sign_a_i  (sign_a),
    .cls_a_i   (cls_a),
    .snan_a_i  (snan_a),
    .sign_b_i  (sign_b),
    .cls_b_i   (cls_b),
    .snan_b_i  (snan_b),
    .mag_lt_i  (mag_lt),
    .mag_eq_i  (mag_eq),
    .cc_o      (cc_next),
    .snan_o    (snan_next),
    .invalid_o (inv_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      cc_q   <= CC_NONE;
      snan_q <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) begin
        // whole field rewritten: old code and flags never survive
        cc_q   <= cc_next;
        snan_q <= snan_next;
        inv_q  <= inv_next;
      end
    end
  end

  assign done_o    = done_q;
  assign cc_o      = cc_q;
  assign snan_o    = snan_q;
  assign invalid_o = inv_q;

endmodule

// File: rtl/fpcmp_chk.sv
module fpcmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       ordered_i,
  input logic       done_o,
  input logic [3:0] cc_o,
  input logic       snan_o,
  input logic       invalid_o
);

  // R2
  start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  // R2
  idle_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);

  // R3
  onehot_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones(cc_o) == 1));

  // R6
  quiet_noinv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !ordered_i) |=> !invalid_o);

  // R5
  snan_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snan_o |-> cc_o[0]);

  // R6
  inv_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> cc_o[0]);

  // R12
  hold_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(cc_o) && $stable(snan_o) && $stable(invalid_o)));

endmodule

bind fpcmp_unit fpcmp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .ordered_i (ordered_i),
  .done_o    (done_o),
  .cc_o      (cc_o),
  .snan_o    (snan_o),
  .invalid_o (invalid_o)
);

// File: tb/fpcmp_unit_test.sv
module fpcmp_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        ordered_i = 1'b0;
  logic [63:0] op_a_i = '0;
  logic [63:0] op_b_i = '0;
  logic        done_o;
  logic [3:0]  cc_o;
  logic        snan_o;
  logic        invalid_o;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  bit finished = 1'b0;

  // model state, updated behaviourally each rising edge
  logic       m_done = 1'b0;
  logic [3:0] m_cc = 4'b0;
  logic       m_snan = 1'b0;
  logic       m_inv = 1'b0;

  localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] NONE_ = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] SUBN  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] NSUBN = 64'h8000_0000_0000_0001;

  fpcmp_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ordered_i(ordered_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .done_o(done_o), .cc_o(cc_o),
    .snan_o(snan_o), .invalid_o(invalid_o)
  );

  always #2 clk = ~clk;

  function automatic bit is_nan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  // expected {cc, snan, invalid} from the requirements, via real arithmetic
  function automatic logic [5:0] ref_cmp(logic [63:0] a, logic [63:0] b, logic ord);
    real ra, rb;
    logic [3:0] cc;
    logic sn, inv;
    sn  = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
    inv = ord && (is_nan(a) || is_nan(b));
    if (is_nan(a) || is_nan(b)) cc = 4'b0001;
    else begin
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      if (ra < rb)      cc = 4'b1000;
      else if (ra > rb) cc = 4'b0100;
      else              cc = 4'b0010;
    end
    return {cc, sn, inv};
  endfunction

  always @(posedge clk) begin
    logic [5:0] r;
    if (!rst_n) begin
      m_done <= 1'b0; m_cc <= 4'b0; m_snan <= 1'b0; m_inv <= 1'b0;
    end else begin
      m_done <= start_i;
      if (start_i) begin
        r = ref_cmp(op_a_i, op_b_i, ordered_i);
        m_cc <= r[5:2]; m_snan <= r[1]; m_inv <= r[0];
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if ({done_o, cc_o, snan_o, invalid_o} !== {m_done, m_cc, m_snan, m_inv}) begin
        errors++;
        $display("FAIL %s: got done=%b cc=%b snan=%b inv=%b expected done=%b cc=%b snan=%b inv=%b",
                 cur_tag, done_o, cc_o, snan_o, invalid_o, m_done, m_cc, m_snan, m_inv);
      end
    end
  end

  task automatic cmp(input logic [63:0] a, input logic [63:0] b, input logic ord,
                     input string tag);
    cur_tag   = tag;
    op_a_i    = a;
    op_b_i    = b;
    ordered_i = ord;
    start_i   = 1'b1;
    @(negedge clk);
    start_i   = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    cur_tag = tag;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // direct check of a fixed expected code, independent of the model
  task automatic expect_cc(input logic [3:0] cc, input logic sn, input logic inv,
                           input string tag);
    checks++;
    if ({cc_o, snan_o, invalid_o} !== {cc, sn, inv}) begin
      errors++;
      $display("FAIL %s: got cc=%b snan=%b inv=%b expected cc=%b snan=%b inv=%b",
               tag, cc_o, snan_o, invalid_o, cc, sn, inv);
    end
  endtask

  function automatic logic [63:0] pick(logic [63:0] other);
    logic [63:0] v;
    case ($urandom_range(0, 9))
      0: v = $urandom_range(0, 1) ? PZERO : NZERO;
      1: v = $urandom_range(0, 1) ? PINF : NINF;
      2: v = {$urandom_range(0,1) ? 1'b1 : 1'b0, 11'h7FF, 1'b1, 51'($urandom())};
      3: v = {$urandom_range(0,1) ? 1'b1 : 1'b0, 11'h7FF, 1'b0, 50'($urandom()), 1'b1};
      4: v = {$urandom_range(0,1) ? 1'b1 : 1'b0, 11'h000, 20'($urandom()), 32'($urandom())};
      5: v = other ^ (64'h1 << $urandom_range(0, 20));
      6: v = other;
      7: v = {other[63], other[62:0] + 63'h1};
      default: v = {32'($urandom()), 32'($urandom())};
    endcase
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    expect_cc(4'b0000, 1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);

    cmp(ONE, TWO, 1'b0, "R11"); expect_cc(4'b1000, 0, 0, "R3 R11 less");
    cmp(TWO, ONE, 1'b0, "R11"); expect_cc(4'b0100, 0, 0, "R11 greater");
    cmp(ONE, ONE, 1'b0, "R11"); expect_cc(4'b0010, 0, 0, "R11 equal");
    cmp(QNAN, ONE, 1'b0, "R4"); expect_cc(4'b0001, 0, 0, "R4 R6 quiet nan");
    cmp(ONE, QNAN, 1'b1, "R6"); expect_cc(4'b0001, 0, 1, "R6 ordered qnan");
    cmp(SNAN, ONE, 1'b0, "R5"); expect_cc(4'b0001, 1, 0, "R5 snan quiet");
    cmp(QNAN, SNAN, 1'b1, "R5"); expect_cc(4'b0001, 1, 1, "R5 snan ordered");
    cmp(PZERO, NZERO, 1'b0, "R7"); expect_cc(4'b0010, 0, 0, "R7 +0 -0");
    cmp(NZERO, PZERO, 1'b1, "R7"); expect_cc(4'b0010, 0, 0, "R7 -0 +0");
    cmp(NZERO, SUBN, 1'b0, "R8"); expect_cc(4'b1000, 0, 0, "R8 -0 vs +sub");
    cmp(PZERO, NSUBN, 1'b0, "R8"); expect_cc(4'b0100, 0, 0, "R8 +0 vs -sub");
    cmp(NINF, PZERO, 1'b0, "R8"); expect_cc(4'b1000, 0, 0, "R8 -inf vs +0");
    cmp(PINF, TWO, 1'b0, "R9"); expect_cc(4'b0100, 0, 0, "R9 inf > fin");
    cmp(NINF, NONE_, 1'b0, "R9"); expect_cc(4'b1000, 0, 0, "R9 neg inversion");
    cmp(NZERO, NSUBN, 1'b0, "R9"); expect_cc(4'b0100, 0, 0, "R9 -0 > -sub");
    cmp(PINF, PINF, 1'b1, "R10"); expect_cc(4'b0010, 0, 0, "R10 +inf");
    cmp(NINF, NINF, 1'b0, "R10"); expect_cc(4'b0010, 0, 0, "R10 -inf");
    cmp(SUBN, 64'h0000_0000_0000_0002, 1'b0, "R11"); expect_cc(4'b1000, 0, 0, "R11 subnormal");
    cmp(64'hBFF0_0000_0000_0002, 64'hBFF0_0000_0000_0001, 1'b0, "R11");
    expect_cc(4'b1000, 0, 0, "R11 low chunk negative");

    // R12: hold, then flags replaced by a clean compare
    cmp(SNAN, QNAN, 1'b1, "R12");
    idle(4, "R12");
    expect_cc(4'b0001, 1, 1, "R12 hold");
    cmp(ONE, TWO, 1'b1, "R12");
    expect_cc(4'b1000, 0, 0, "R12 flags replaced");

    // R2: back-to-back starts, alternating variants
    cur_tag = "R2";
    for (int i = 0; i < 40; i++) begin
      op_a_i = pick(ONE); op_b_i = pick(op_a_i);
      ordered_i = i[0]; start_i = 1'b1;
      @(negedge clk);
    end
    start_i = 1'b0;
    idle(2, "R2");

    // weighted random with gaps
    for (int i = 0; i < 600; i++) begin
      logic [63:0] a;
      a = pick(TWO);
      cmp(a, pick(a), 1'($urandom_range(0, 1)), "R3");
      if ($urandom_range(0, 3) == 0) idle(1, "R12");
    end

    // R1: reset mid-stream
    cmp(QNAN, SNAN, 1'b1, "R1");
    rst_n = 1'b0; cur_tag = "R1";
    @(negedge clk);
    expect_cc(4'b0000, 0, 0, "R1 reset");
    rst_n = 1'b1;
    idle(2, "R1");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion expected end of test");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule